// File: doc/BRIEF.md
# Segmented Masked CAM Comparand Unit

This block holds the search state of a small content-addressable match array whose entries are wider than the data bus. Each 64-bit entry, the comparand and the two mask registers are split into four 16-bit segments. The host loads them one segment per write cycle. A write segment counter picks the segment that each write touches. The counter steps from a programmable start segment to a programmable stop segment and then returns to the start.

Writes to the comparand or to a memory word can be filtered through either mask register. Bits whose selected mask bit is 1 keep their old value. Completing the stop segment of the comparand or of a mask register raises a compare request. Writing a memory word never raises one. The compare checks the lower segments of every valid entry against the comparand and ignores the upper data-only segment. It reports the lowest matching address, and one chosen segment of that entry is returned on the read port.

Top module: `cam_cmp_unit`

## Requirements
- R1: After a synchronous reset, `cmp_req`, `match_flag`, `match_addr` and `rd_data` are all 0. The write segment counter is at segment 0. All entries are invalid, and the comparand and both masks are zero.
- R2: Each cycle with `wr_en` high writes the segment the counter points at, then moves the counter on by one. At `seg_stop` the counter returns to `seg_start`. `seg_load` sets the counter to `seg_start`, so with start 1 and stop 3 the writes go to segments 1, 2, 3, 1, and so on.
- R3: A write to the comparand (`wr_dst`=0) or to a memory word (`wr_dst`=3) uses the mask chosen by `wr_msel`: 1 selects mask register 1, 2 selects mask register 2, and 0 or 3 disables masking. Only the destination bits whose mask bit is 0 take the new data.
- R4: Writes to mask register 1 (`wr_dst`=1) and mask register 2 (`wr_dst`=2) are never masked, whatever `wr_msel` is.
- R5: `cmp_req` is high for exactly the one cycle after a write that hits the stop segment with `wr_dst` set to 0, 1 or 2.
- R6: A write to memory (`wr_dst`=3) never raises `cmp_req`, even when it hits the stop segment.
- R7: Compare results update only in the cycle after `cmp_req` and hold otherwise. Only the lower CAM_SEGS segments (bits 47:0 by default) take part in matching. The top segment is data only.
- R8: A memory write sets the validity bit of entry `wr_addr` to `wr_vld`. Invalid entries never match.
- R9: When several valid entries match, `match_flag` is 1 and `match_addr` is the lowest matching address. When none match, `match_flag` and `match_addr` are 0.
- R10: One cycle after the match result, `rd_data` carries segment `rd_seg` of the entry at `match_addr`, and keeps following `rd_seg` with one cycle of latency. When `match_flag` is 0, `rd_data` is 0.
- R11: With `cmp_mask_en` high, the compare ignores every CAM bit whose mask register 1 bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_load | input | 1 | Load the write segment counter with `seg_start` |
| seg_start | input | 2 | First segment of the write sequence |
| seg_stop | input | 2 | Last segment of the write sequence (wrap point) |
| rd_seg | input | 2 | Segment of the matched entry driven on `rd_data` |
| wr_en | input | 1 | Segment write strobe |
| wr_dst | input | 2 | Destination: 0 comparand, 1 mask 1, 2 mask 2, 3 memory |
| wr_msel | input | 2 | Write mask: 0 none, 1 mask 1, 2 mask 2, 3 none |
| wr_addr | input | 4 | Memory entry addressed by a memory write |
| wr_vld | input | 1 | Validity given to the addressed entry on a memory write |
| wr_data | input | 16 | Segment write data |
| cmp_mask_en | input | 1 | Exclude mask-1 bits from the compare |
| cmp_req | output | 1 | Compare request, one cycle after the completing write |
| match_flag | output | 1 | At least one valid entry matched |
| match_addr | output | 4 | Lowest matching address |
| rd_data | output | 16 | Selected segment of the matched entry |

## Verification
The comparand and mask registers cannot be read back, so a wrong segment counter or a misapplied mask shows only at the compare. A bad value surfaces as a wrong `match_flag`/`match_addr` two cycles after the completing write, and as a wrong `rd_data` one cycle later. A lost or spurious request shows already on `cmp_req` in the cycle after the write. A corrupted memory segment outside the CAM field shows only through `rd_data`, so the bench reads every segment of each matched entry.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [1:0] {
    DST_CMP  = 2'd0,
    DST_MSK1 = 2'd1,
    DST_MSK2 = 2'd2,
    DST_MEM  = 2'd3
  } dst_e;

  typedef enum logic [1:0] {
    MSEL_NONE = 2'd0,
    MSEL_M1   = 2'd1,
    MSEL_M2   = 2'd2,
    MSEL_OFF  = 2'd3
  } msel_e;

endpackage

// File: rtl/cam_seg_ctr.sv
module cam_seg_ctr #(
  parameter int NSEG = 4,
  localparam int SB = $clog2(NSEG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [SB-1:0] start,
  input  logic [SB-1:0] stop,
  output logic [SB-1:0] seg,
  output logic          wrap
);

  logic [SB-1:0] seg_q;
  logic [SB-1:0] seg_inc;

  always_comb begin
    if (seg_q == SB'(NSEG - 1)) seg_inc = '0;
    else                        seg_inc = seg_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       seg_q <= '0;
    else if (load) seg_q <= start;
    else if (step) seg_q <= (seg_q == stop) ? start : seg_inc;
  end

  assign seg  = seg_q;
  assign wrap = step && (seg_q == stop);

endmodule

// File: rtl/cam_mask_merge.sv
module cam_mask_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] new_val,
  input  logic [W-1:0] keep,
  output logic [W-1:0] merged
);

  assign merged = (old_val & keep) | (new_val & ~keep);

endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/cam_cmp_unit.sv
module cam_cmp_unit
  import cam_pkg::*;
#(
  parameter int SEG_W    = 16,
  parameter int NSEG     = 4,
  parameter int CAM_SEGS = 3,
  parameter int DEPTH    = 16,
  localparam int SB        = $clog2(NSEG),
  localparam int ADDR_BITS = $clog2(DEPTH),
  localparam int ENTRY_W   = SEG_W * NSEG,
  localparam int CAM_W     = SEG_W * CAM_SEGS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 seg_load,
  input  logic [SB-1:0]        seg_start,
  input  logic [SB-1:0]        seg_stop,
  input  logic [SB-1:0]        rd_seg,
  input  logic                 wr_en,
  input  logic [1:0]           wr_dst,
  input  logic [1:0]           wr_msel,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic                 wr_vld,
  input  logic [SEG_W-1:0]     wr_data,
  input  logic                 cmp_mask_en,
  output logic                 cmp_req,
  output logic                 match_flag,
  output logic [ADDR_BITS-1:0] match_addr,
  output logic [SEG_W-1:0]     rd_data
);

  dst_e  dst;
  msel_e msel;
  assign dst  = dst_e'(wr_dst);
  assign msel = msel_e'(wr_msel);

  // storage
  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]   vld_q;
  logic [ENTRY_W-1:0] cmp_q;
  logic [ENTRY_W-1:0] msk1_q;
  logic [ENTRY_W-1:0] msk2_q;

  // write segment sequencing
  logic [SB-1:0] seg;
  logic          wrap;

  cam_seg_ctr #(.NSEG(NSEG)) u_seg_ctr (
    .clk   (clk),
    .rst   (rst),
    .load  (seg_load),
    .step  (wr_en),
    .start (seg_start),
    .stop  (seg_stop),
    .seg   (seg),
    .wrap  (wrap)
  );

  // masked segment merge
  logic [SEG_W-1:0] old_seg;
  logic [SEG_W-1:0] keep_seg;
  logic [SEG_W-1:0] merged_seg;

  always_comb begin
    if (dst == DST_MEM) old_seg = mem_q[wr_addr][seg*SEG_W +: SEG_W];
    else                old_seg = cmp_q[seg*SEG_W +: SEG_W];
    case (msel)
      MSEL_M1: keep_seg = msk1_q[seg*SEG_W +: SEG_W];
      MSEL_M2: keep_seg = msk2_q[seg*SEG_W +: SEG_W];
      default: keep_seg = '0;
    endcase
  end

  cam_mask_merge #(.W(SEG_W)) u_merge (
    .old_val (old_seg),
    .new_val (wr_data),
    .keep    (keep_seg),
    .merged  (merged_seg)
  );

  logic cmp_req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q     <= '0;
      msk1_q    <= '0;
      msk2_q    <= '0;
      vld_q     <= '0;
      cmp_req_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cmp_req_q <= wr_en && wrap && (dst != DST_MEM);
      if (wr_en) begin
        case (dst)
          DST_CMP:  cmp_q[seg*SEG_W +: SEG_W]  <= merged_seg;
          DST_MSK1: msk1_q[seg*SEG_W +: SEG_W] <= wr_data;
          DST_MSK2: msk2_q[seg*SEG_W +: SEG_W] <= wr_data;
          default: begin
            mem_q[wr_addr][seg*SEG_W +: SEG_W] <= merged_seg;
            vld_q[wr_addr] <= wr_vld;
          end
        endcase
      end
    end
  end

  // parallel compare over the CAM field
  logic [CAM_W-1:0] ign_bits;
  logic [DEPTH-1:0] hit;
  assign ign_bits = cmp_mask_en ? msk1_q[CAM_W-1:0] : '0;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_hit
    assign hit[gi] = vld_q[gi] &&
      (((mem_q[gi][CAM_W-1:0] ^ cmp_q[CAM_W-1:0]) & ~ign_bits) == '0);
  end

  logic                 any_hit;
  logic [ADDR_BITS-1:0] hit_idx;

  cam_prio_enc #(.N(DEPTH)) u_prio (
    .req   (hit),
    .found (any_hit),
    .idx   (hit_idx)
  );

  logic                 flag_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic [SEG_W-1:0]     rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      rd_q   <= '0;
    end else begin
      if (cmp_req_q) begin
        flag_q <= any_hit;
        addr_q <= any_hit ? hit_idx : '0;
      end
      rd_q <= flag_q ? mem_q[addr_q][rd_seg*SEG_W +: SEG_W] : '0;
    end
  end

  assign cmp_req    = cmp_req_q;
  assign match_flag = flag_q;
  assign match_addr = addr_q;
  assign rd_data    = rd_q;

endmodule

// File: rtl/cam_cmp_chk.sv
module cam_cmp_chk #(
  parameter int SEG_W = 16,
  parameter int AB    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_dst,
  input logic          cmp_req,
  input logic          match_flag,
  input logic [AB-1:0] match_addr,
  input logic [SEG_W-1:0] rd_data
);

  AST_REQ_FROM_REG_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmp_req |-> ($past(wr_en) && $past(wr_dst) != 2'd3)); // R5

  AST_NO_MEM_REQ: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_dst == 2'd3) |=> !cmp_req); // R6

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(cmp_req) |-> ($stable(match_flag) && $stable(match_addr))); // R7

  AST_ADDR_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !match_flag |-> match_addr == '0); // R9

  AST_RD_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !$past(match_flag) |-> rd_data == '0); // R10

endmodule

bind cam_cmp_unit cam_cmp_chk #(.SEG_W(SEG_W), .AB(ADDR_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_dst     (wr_dst),
  .cmp_req    (cmp_req),
  .match_flag (match_flag),
  .match_addr (match_addr),
  .rd_data    (rd_data)
);

// File: tb/test_cam_cmp_unit.sv
`timescale 1ns/1ps
module test_cam_cmp_unit;

  localparam int NS = 4;
  localparam int DP = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        seg_load;
  logic [1:0]  seg_start, seg_stop, rd_seg;
  logic        wr_en;
  logic [1:0]  wr_dst, wr_msel;
  logic [3:0]  wr_addr;
  logic        wr_vld;
  logic [15:0] wr_data;
  logic        cmp_mask_en;
  logic        cmp_req, match_flag;
  logic [3:0]  match_addr;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  cam_cmp_unit i_cam_cmp_unit (
    .clk(clk), .rst(rst), .seg_load(seg_load), .seg_start(seg_start),
    .seg_stop(seg_stop), .rd_seg(rd_seg), .wr_en(wr_en), .wr_dst(wr_dst),
    .wr_msel(wr_msel), .wr_addr(wr_addr), .wr_vld(wr_vld), .wr_data(wr_data),
    .cmp_mask_en(cmp_mask_en), .cmp_req(cmp_req), .match_flag(match_flag),
    .match_addr(match_addr), .rd_data(rd_data)
  );

  // reference model
  logic [63:0] mem_m [DP];
  logic [DP-1:0] vld_m;
  logic [63:0] cmp_m, m1_m, m2_m;
  logic [1:0]  seg_m, start_m, stop_m;
  bit          req_m;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] merge_f(input logic [15:0] o, input logic [15:0] d, input logic [15:0] k);
    return (o & k) | (d & ~k);
  endfunction

  function automatic bit hit_f(input int i);
    logic [47:0] ign;
    ign = cmp_mask_en ? m1_m[47:0] : 48'h0;
    return vld_m[i] && (((mem_m[i][47:0] ^ cmp_m[47:0]) & ~ign) == 48'h0);
  endfunction

  function automatic int first_hit_f();
    for (int i = 0; i < DP; i++) if (hit_f(i)) return i;
    return -1;
  endfunction

  task automatic seg_cfg(input logic [1:0] s, input logic [1:0] e);
    @(negedge clk);
    seg_start = s; seg_stop = e; seg_load = 1'b1;
    @(negedge clk);
    seg_load = 1'b0;
    start_m = s; stop_m = e; seg_m = s;
  endtask

  // one segment write; returns at the negedge after the sampling edge
  task automatic wr_seg(input logic [1:0] d, input logic [1:0] ms, input logic [3:0] a,
                        input logic v, input logic [15:0] dat);
    logic [15:0] keep;
    @(negedge clk);
    wr_en = 1'b1; wr_dst = d; wr_msel = ms; wr_addr = a; wr_vld = v; wr_data = dat;
    keep = (ms == 2'd1) ? m1_m[seg_m*16 +: 16] : (ms == 2'd2) ? m2_m[seg_m*16 +: 16] : 16'h0;
    case (d)
      2'd0: cmp_m[seg_m*16 +: 16] = merge_f(cmp_m[seg_m*16 +: 16], dat, keep);
      2'd1: m1_m[seg_m*16 +: 16] = dat;
      2'd2: m2_m[seg_m*16 +: 16] = dat;
      default: begin
        mem_m[a][seg_m*16 +: 16] = merge_f(mem_m[a][seg_m*16 +: 16], dat, keep);
        vld_m[a] = v;
      end
    endcase
    req_m = (seg_m == stop_m) && (d != 2'd3);
    seg_m = (seg_m == stop_m) ? start_m : seg_m + 2'd1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // checks the compare and every read segment after a completing write
  task automatic check_cmp(input string tag);
    int w;
    chk(cmp_req == 1'b1, {tag, " R5 cmp_req"}, cmp_req, 1);
    w = first_hit_f();
    @(negedge clk);
    chk(cmp_req == 1'b0, {tag, " R5 one-cycle cmp_req"}, cmp_req, 0);
    chk(match_flag == (w >= 0), {tag, " R9 match_flag"}, match_flag, w >= 0);
    chk(match_addr == ((w >= 0) ? w[3:0] : 4'd0), {tag, " R9 match_addr"}, match_addr, (w >= 0) ? w : 0);
    for (int s = 0; s < NS; s++) begin
      rd_seg = 2'(s);
      @(negedge clk);
      @(negedge clk);
      chk(rd_data == ((w >= 0) ? mem_m[w][s*16 +: 16] : 16'h0), {tag, " R10 rd_data"},
          rd_data, (w >= 0) ? mem_m[w][s*16 +: 16] : 0);
    end
  endtask

  task automatic wr_full(input logic [1:0] d, input logic [1:0] ms, input logic [3:0] a,
                         input logic v, input logic [63:0] val, input string tag);
    seg_cfg(2'd0, 2'd3);
    for (int s = 0; s < NS; s++) begin
      wr_seg(d, ms, a, v, val[s*16 +: 16]);
      if (s < NS - 1) chk(cmp_req == 1'b0, {tag, " R5 no early cmp_req"}, cmp_req, 0);
    end
    if (d == 2'd3) chk(cmp_req == 1'b0, {tag, " R6 memory write no cmp_req"}, cmp_req, 0);
    else check_cmp(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a_val;
    void'($urandom(32'h5EED_C0DE));
    rst = 1'b1; seg_load = 0; seg_start = 0; seg_stop = 3; rd_seg = 0; wr_en = 0;
    wr_dst = 0; wr_msel = 0; wr_addr = 0; wr_vld = 0; wr_data = 0; cmp_mask_en = 0;
    for (int i = 0; i < DP; i++) mem_m[i] = 64'h0;
    vld_m = '0; cmp_m = 0; m1_m = 0; m2_m = 0; seg_m = 0; start_m = 0; stop_m = 3; req_m = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmp_req == 0 && match_flag == 0, "R1 reset flags", {cmp_req, match_flag}, 0);
    chk(match_addr == 0 && rd_data == 0, "R1 reset addr/data", {match_addr, rd_data}, 0);
    // R1: counter at 0 -> first write without load lands in segment 0; a plain
    // comparand load of zero on all-invalid memory finds nothing
    for (int s = 0; s < NS; s++) wr_seg(2'd0, 2'd0, 0, 0, 16'h0);
    check_cmp("R1 R8 empty array");

    // directed: duplicates, lowest address wins
    a_val = 64'hDEAD_1234_5678_9ABC;
    wr_full(2'd3, 2'd0, 4'd9, 1'b0, a_val, "R8 invalid entry");
    wr_full(2'd3, 2'd0, 4'd5, 1'b1, {16'h1111, a_val[47:0]}, "mem5");
    wr_full(2'd3, 2'd0, 4'd2, 1'b1, {16'h2222, a_val[47:0]}, "mem2");
    wr_full(2'd0, 2'd0, 4'd0, 1'b0, a_val, "R9 lowest of 2 and 5");
    wr_full(2'd0, 2'd0, 4'd0, 1'b0, {16'h7777, a_val[47:0]}, "R7 top segment ignored");
    wr_full(2'd3, 2'd0, 4'd2, 1'b0, {16'h2222, a_val[47:0]}, "R8 invalidate 2");
    wr_full(2'd0, 2'd0, 4'd0, 1'b0, a_val, "R8 only valid 5");
    wr_full(2'd0, 2'd0, 4'd0, 1'b0, 64'h0, "R9 R10 no match");

    // R4: mask writes ignore wr_msel; R3 masked memory and comparand writes
    wr_full(2'd2, 2'd1, 4'd0, 1'b0, 64'h00FF_00FF_00FF_00FF, "R4 mask2 load");
    wr_full(2'd1, 2'd2, 4'd0, 1'b0, 64'hFFFF_0000_F0F0_0F0F, "R4 mask1 load");
    wr_full(2'd3, 2'd2, 4'd5, 1'b1, 64'hABCD_ABCD_ABCD_ABCD, "R3 mask2 memory write");
    wr_full(2'd0, 2'd1, 4'd0, 1'b0, mem_m[5], "R3 mask1 comparand write");
    wr_full(2'd0, 2'd3, 4'd0, 1'b0, mem_m[5], "R3 unmasked comparand write");
    cmp_mask_en = 1'b1;
    wr_full(2'd0, 2'd0, 4'd0, 1'b0, mem_m[5] ^ 64'h0000_F0F0_0F0F, "R11 compare masking");
    cmp_mask_en = 1'b0;

    // R2: segments 1..3 wrap, request on segment 3 only
    seg_cfg(2'd1, 2'd3);
    wr_seg(2'd0, 2'd0, 0, 0, 16'h1AAA);
    chk(cmp_req == 0, "R2 seg1 no req", cmp_req, 0);
    wr_seg(2'd0, 2'd0, 0, 0, 16'h2BBB);
    chk(cmp_req == 0, "R2 seg2 no req", cmp_req, 0);
    wr_seg(2'd0, 2'd0, 0, 0, mem_m[5][47:32]);
    check_cmp("R2 seg3 wrap");
    wr_seg(2'd0, 2'd0, 0, 0, mem_m[5][15:0]);
    chk(cmp_req == 0, "R2 wrapped to seg1", cmp_req, 0);
    wr_seg(2'd0, 2'd0, 0, 0, mem_m[5][31:16]);
    wr_seg(2'd0, 2'd0, 0, 0, mem_m[5][47:32]);
    check_cmp("R2 second pass");

    // random phase
    for (int it = 0; it < 40; it++) begin
      logic [63:0] v;
      int pick;
      v = {$urandom, $urandom};
      case ($urandom % 4)
        0: wr_full(2'd1, 2'($urandom), 0, 0, v & {$urandom, $urandom}, "R4 rnd mask1");
        1: wr_full(2'd2, 2'($urandom), 0, 0, {$urandom, $urandom}, "R4 rnd mask2");
        default: wr_full(2'd3, 2'($urandom), 4'($urandom), 1'($urandom % 4 != 0), v, "R3 rnd mem");
      endcase
      cmp_mask_en = 1'($urandom % 3 == 0);
      pick = $urandom % DP;
      v = ($urandom % 4 != 0) ? {16'($urandom), mem_m[pick][47:0]} : {$urandom, $urandom};
      wr_full(2'd0, 2'($urandom), 0, 0, v, "R7 R9 R11 rnd compare");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule